// File: doc/BRIEF.md
# Serial Memory Erase and Ready/Busy Controller

This block is the device side of a small serial word memory with a three-wire command interface: chip select, a serial clock and a serial data input. It handles only the erase command. Once it has decoded a start bit, a two-bit opcode and an address, it runs a self-timed erase that fills the addressed word with ones. While that erase runs, and after it ends, the block reports its state on a data output that can be turned off, which is modelled here as a separate data signal and enable signal.

All three inputs pass through two-flop synchronizers into the system clock domain and are handled by their edges. The erase length is counted in system clocks. The minimum chip-select low time that arms status reporting is also counted in system clocks. A parameter selects what starts the erase. By default, chip select falling after the final address bit starts it. In the other mode, the serial clock edge that captures the final address bit starts it. The memory is a register array. It clears to zero at reset and can be inspected through a combinational read port.

Top module: `mw_erase_ctrl`

## Requirements
- R1: After reset, doEn is 0 and every memory word reads 0 on rdData. No status is shown before any erase has started.
- R2: A frame is made of the following bits, each sampled on a rising serial clock edge while chip select is high: a start bit of 1, then the opcode bits, then ADDR_W address bits with the most significant bit first. Only opcode 2'b11 erases. Any other opcode leaves the memory unchanged.
- R3: In the default mode (CLK_TRIG=0), chip select falling after a complete erase frame starts the erase. ERASE_CYCLES clocks later, every bit of the addressed word reads 1.
- R4: With CLK_TRIG=1, the erase starts on the serial clock rising edge that samples the final address bit, even while chip select stays high.
- R5: If chip select falls before every address bit has arrived, the frame is dropped and no word changes.
- R6: A frame sent while an erase is running is ignored.
- R7: Suppose an erase has started since status was last cleared, and chip select then rises after being low for at least CSL_MIN clocks. Then doEn is 1 while chip select stays high. doData is 0 while the erase runs and 1 once it is done.
- R8: If chip select was low for fewer than CSL_MIN clocks before it rises, status is not shown (doEn 0).
- R9: When no erase is running, a start bit followed by chip select falling before the frame is complete clears the status. A later chip select rise then leaves doEn at 0.
- R10: doEn is 0 whenever chip select is low, and from the moment a start bit is captured.
- R11: An erase changes only the addressed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csIn | input | 1 | Chip select, asynchronous |
| sclkIn | input | 1 | Serial clock, asynchronous |
| diIn | input | 1 | Serial data in, asynchronous |
| doData | output | 1 | Serial data out value (status) |
| doEn | output | 1 | Serial data out drive enable; 0 means high impedance |
| rdAddr | input | ADDR_W | Memory model inspection address |
| rdData | output | DATA_W | Memory model word at rdAddr |

## Verification
The assertions assume the serial inputs change slowly compared with the system clock. Each level of data in and of the serial clock must last at least two system clocks, so that the synchronized data bit is settled when the synchronized clock edge is seen. They also assume that no frame is sent during reset. The bench drives every input on the falling system clock edge and holds every serial level for several clocks. Its random frames vary the address, the opcode and the abort point, and each frame waits out the full erase time before the next one begins. The only frames sent during an erase are those in the directed test of the busy-ignore rule.

// File: rtl/mw_erase_pkg.sv
package mw_erase_pkg;
  // Strobes from the command control to the erase datapath
  typedef struct packed {
    logic eraseGo;    // start a timed erase at eraseAddr
    logic statusClr;  // drop the pending status
  } ctlStrobe_t;

  localparam logic [1:0] OP_ERASE = 2'b11;
endpackage

// File: rtl/mw_erase_ctl.sv
module mw_erase_ctl
  import mw_erase_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int CSL_MIN  = 6,
  parameter bit CLK_TRIG = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csIn,
  input  logic              sclkIn,
  input  logic              diIn,
  input  logic              busy,
  input  logic              pending,
  output ctlStrobe_t        strobe,
  output logic [ADDR_W-1:0] eraseAddr,
  output logic              doData,
  output logic              doEn
);
  localparam int CNT_W = $clog2(ADDR_W + 3);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(ADDR_W + 1);
  localparam int LOW_W = $clog2(CSL_MIN + 1);
  localparam logic [LOW_W-1:0] LOW_MAX = LOW_W'(CSL_MIN);

  logic [1:0] csQ, sclkQ, diQ;
  logic csPrev, sclkPrev;
  logic csS, sclkS, diS;
  logic csRise, csFall, sclkRise;
  logic inFrame, frameDone, statusShow;
  logic [CNT_W-1:0] bitCnt;
  logic [1:0] opQ;
  logic [ADDR_W-1:0] addrQ;
  logic [LOW_W-1:0] csLowCnt;
  logic eraseGo, takeBit;

  assign csS      = csQ[1];
  assign sclkS    = sclkQ[1];
  assign diS      = diQ[1];
  assign csRise   = csS & ~csPrev;
  assign csFall   = ~csS & csPrev;
  assign sclkRise = sclkS & ~sclkPrev;
  assign takeBit  = sclkRise & csS & ~busy;

  // The address includes the bit arriving now when the erase starts on a clock edge
  assign eraseAddr = frameDone ? addrQ : {addrQ[ADDR_W-2:0], diS};

  generate
    if (CLK_TRIG) begin : g_clkTrig
      assign eraseGo = takeBit & inFrame & ~frameDone &
                       (bitCnt == LAST_BIT) & (opQ == OP_ERASE);
    end else begin : g_csTrig
      assign eraseGo = csFall & frameDone & ~busy & (opQ == OP_ERASE);
    end
  endgenerate

  assign strobe.eraseGo   = eraseGo;
  assign strobe.statusClr = csFall & inFrame & ~frameDone & ~busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csQ <= '0; sclkQ <= '0; diQ <= '0;
      csPrev <= 1'b0; sclkPrev <= 1'b0;
      inFrame <= 1'b0; frameDone <= 1'b0; statusShow <= 1'b0;
      bitCnt <= '0; opQ <= '0; addrQ <= '0; csLowCnt <= '0;
    end else begin
      csQ      <= {csQ[0], csIn};
      sclkQ    <= {sclkQ[0], sclkIn};
      diQ      <= {diQ[0], diIn};
      csPrev   <= csS;
      sclkPrev <= sclkS;

      if (csS)                   csLowCnt <= '0;
      else if (csLowCnt != LOW_MAX) csLowCnt <= csLowCnt + 1'b1;

      if (csFall) begin
        inFrame    <= 1'b0;
        frameDone  <= 1'b0;
        statusShow <= 1'b0;
      end else if (csRise) begin
        statusShow <= pending & (csLowCnt >= LOW_MAX);
      end else if (takeBit) begin
        if (!inFrame) begin
          if (diS) begin
            inFrame    <= 1'b1;
            bitCnt     <= '0;
            statusShow <= 1'b0;
          end
        end else if (!frameDone) begin
          if (bitCnt < CNT_W'(2)) opQ <= {opQ[0], diS};
          else                    addrQ <= {addrQ[ADDR_W-2:0], diS};
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == LAST_BIT) frameDone <= 1'b1;
        end
      end
    end
  end

  assign doEn   = csS & statusShow;
  assign doData = doEn & ~busy;

  a_r10_hiz_after_cs_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csS) |=> !doEn);
  a_r7_status_needs_pending: assert property (@(posedge clk) disable iff (!rstN)
    doEn |-> pending);
  a_r6_no_go_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    strobe.eraseGo |-> !busy);
endmodule

// File: rtl/mw_erase_dp.sv
module mw_erase_dp
  import mw_erase_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int DATA_W       = 16,
  parameter int ERASE_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] eraseAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              pending
);
  localparam int WORDS = 1 << ADDR_W;
  localparam int TMR_W = $clog2(ERASE_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(ERASE_CYCLES - 1);

  logic [DATA_W-1:0] memQ [WORDS];
  logic [TMR_W-1:0]  tmrQ;
  logic [ADDR_W-1:0] addrL;
  logic              busyQ, pendingQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) memQ[i] <= '0;
      tmrQ <= '0; addrL <= '0; busyQ <= 1'b0; pendingQ <= 1'b0;
    end else begin
      if (strobe.eraseGo && !busyQ) begin
        busyQ    <= 1'b1;
        tmrQ     <= TMR_LOAD;
        addrL    <= eraseAddr;
        pendingQ <= 1'b1;
      end else begin
        if (strobe.statusClr) pendingQ <= 1'b0;
        if (busyQ) begin
          if (tmrQ == '0) begin
            busyQ       <= 1'b0;
            memQ[addrL] <= '1;
          end else begin
            tmrQ <= tmrQ - 1'b1;
          end
        end
      end
    end
  end

  assign rdData  = memQ[rdAddr];
  assign busy    = busyQ;
  assign pending = pendingQ;

  a_r3_erase_fills_word: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> (memQ[addrL] == '1));
  a_r7_busy_keeps_pending: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> pendingQ);
endmodule

// File: rtl/mw_erase_ctrl.sv
module mw_erase_ctrl
  import mw_erase_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int DATA_W       = 16,
  parameter int ERASE_CYCLES = 200,
  parameter int CSL_MIN      = 6,
  parameter bit CLK_TRIG     = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csIn,
  input  logic              sclkIn,
  input  logic              diIn,
  output logic              doData,
  output logic              doEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  ctlStrobe_t        strobe;
  logic [ADDR_W-1:0] eraseAddr;
  logic              busy, pending;

  mw_erase_ctl #(.ADDR_W(ADDR_W), .CSL_MIN(CSL_MIN), .CLK_TRIG(CLK_TRIG)) u_ctl (
    .clk(clk), .rstN(rstN), .csIn(csIn), .sclkIn(sclkIn), .diIn(diIn),
    .busy(busy), .pending(pending), .strobe(strobe), .eraseAddr(eraseAddr),
    .doData(doData), .doEn(doEn)
  );

  mw_erase_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERASE_CYCLES(ERASE_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .eraseAddr(eraseAddr),
    .rdAddr(rdAddr), .rdData(rdData), .busy(busy), .pending(pending)
  );
endmodule

// File: tb/mw_erase_ctrl_bench.sv
module mw_erase_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int EC = 150;
  localparam int CM = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0, cs = 1'b0, sclk = 1'b0, di = 1'b0;
  logic [AW-1:0] rdAddr = '0;
  logic doData, doEn, altData, altEn;
  logic [DW-1:0] rdData, altRd;
  int checks = 0, failures = 0;
  logic [DW-1:0] expMem [1 << AW];

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_erase_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ERASE_CYCLES(EC), .CSL_MIN(CM), .CLK_TRIG(1'b0))
    u_mw_erase_ctrl (.clk(clk), .rstN(rstN), .csIn(cs), .sclkIn(sclk), .diIn(di),
      .doData(doData), .doEn(doEn), .rdAddr(rdAddr), .rdData(rdData));

  mw_erase_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ERASE_CYCLES(EC), .CSL_MIN(CM), .CLK_TRIG(1'b1))
    u_alt (.clk(clk), .rstN(rstN), .csIn(cs), .sclkIn(sclk), .diIn(di),
      .doData(altData), .doEn(altEn), .rdAddr(rdAddr), .rdData(altRd));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    di = b; tick(2); sclk = 1'b1; tick(3); sclk = 1'b0; tick(1);
  endtask

  task automatic csHigh();
    cs = 1'b1; tick(4);
  endtask

  task automatic csLow(input int n);
    cs = 1'b0; di = 1'b0; tick(n);
  endtask

  // start bit, then nBits of {op, addr} MSB first
  task automatic sendFrame(input logic [1:0] op, input logic [AW-1:0] a, input int nBits);
    logic [AW+1:0] word;
    word = {op, a};
    sendBit(1'b1);
    for (int i = 0; i < nBits; i++) sendBit(word[AW+1-i]);
  endtask

  function automatic bit eraseExpected(input logic [1:0] op, input int nBits);
    return (op == 2'b11) && (nBits == AW + 2);
  endfunction

  task automatic checkWord(input string req, input logic [AW-1:0] a);
    rdAddr = a; tick(1);
    check(req, $sformatf("default word %0d", a), 32'(rdData), 32'(expMem[a]));
    check(req, $sformatf("alt word %0d", a), 32'(altRd), 32'(expMem[a]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [AW-1:0] ra, other;
    logic [1:0] rop;
    int nb;
    void'($urandom(32'd4242));
    for (int i = 0; i < (1 << AW); i++) expMem[i] = '0;
    tick(5); rstN = 1'b1; tick(5);

    // R1 reset state
    check("R1", "doEn after reset", 32'(doEn), 0);
    check("R1", "alt doEn after reset", 32'(altEn), 0);
    checkWord("R1", 0); checkWord("R1", 63);
    cs = 1'b1; tick(6);
    check("R1", "no status before any erase", 32'(doEn), 0);
    csLow(10);

    // R3/R7/R10/R9 default erase with status
    csHigh(); sendFrame(2'b11, 6'd5, AW + 2);
    cs = 1'b0; tick(12); cs = 1'b1; tick(5);
    check("R7", "doEn busy", 32'(doEn), 1);
    check("R7", "doData busy", 32'(doData), 0);
    checkWord("R3", 5);
    tick(EC + 20);
    check("R7", "doData done", 32'(doData), 1);
    expMem[5] = '1;
    checkWord("R3", 5); checkWord("R11", 4); checkWord("R11", 6);
    sendBit(1'b1);
    check("R10", "doEn after start bit", 32'(doEn), 0);
    cs = 1'b0; tick(3);
    check("R10", "doEn cs low", 32'(doEn), 0);
    tick(10); cs = 1'b1; tick(5);
    check("R9", "status cleared", 32'(doEn), 0);
    csLow(10);

    // R8 short low then long low
    csHigh(); sendFrame(2'b11, 6'd9, AW + 2);
    csLow(12); cs = 1'b1; tick(EC + 20);
    expMem[9] = '1;
    cs = 1'b0; tick(2); cs = 1'b1; tick(5);
    check("R8", "short low no status", 32'(doEn), 0);
    cs = 1'b0; tick(12); cs = 1'b1; tick(5);
    check("R7", "long low shows status", 32'(doEn), 1);
    check("R7", "ready value", 32'(doData), 1);
    sendBit(1'b1); csLow(10);
    checkWord("R3", 9);

    // R2 wrong opcodes
    csHigh(); sendFrame(2'b10, 6'd12, AW + 2); csLow(10); tick(EC + 20);
    checkWord("R2", 12);
    csHigh(); sendFrame(2'b01, 6'd12, AW + 2); csLow(10); tick(EC + 20);
    checkWord("R2", 12);

    // R5 abort one bit short
    csHigh(); sendFrame(2'b11, 6'd13, AW + 1); csLow(10); tick(EC + 20);
    checkWord("R5", 13);

    // R4 clock-edge trigger with cs held high
    csHigh(); sendFrame(2'b11, 6'd20, AW + 2); tick(EC + 20);
    rdAddr = 6'd20; tick(1);
    check("R4", "alt erased with cs high", 32'(altRd), 32'(16'hFFFF));
    check("R4", "default waits for cs fall", 32'(rdData), 0);
    csLow(10); tick(EC + 20);
    expMem[20] = '1;
    checkWord("R3", 20);

    // R6 frame during busy is ignored
    csHigh(); sendFrame(2'b11, 6'd30, AW + 2); csLow(6);
    csHigh(); sendFrame(2'b11, 6'd31, AW + 2); csLow(10);
    tick(EC + 40);
    expMem[30] = '1;
    checkWord("R6", 30); checkWord("R6", 31);

    // random frames
    for (int k = 0; k < 30; k++) begin
      ra  = AW'($urandom);
      rop = ($urandom % 4 == 0) ? 2'($urandom) : 2'b11;
      nb  = ($urandom % 5 == 0) ? int'($urandom % (AW + 2)) : AW + 2;
      csHigh(); sendFrame(rop, ra, nb); csLow(10); tick(EC + 20);
      if (eraseExpected(rop, nb)) expMem[ra] = '1;
      checkWord("R2", ra);
      other = AW'($urandom);
      checkWord("R11", other);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule